// File: doc/BRIEF.md
# FIFO Interrupt and DMA Request Controller

This block turns the state of a streaming peripheral's two data queues into service requests. It keeps five sticky status flags: input queue low, output queue high, output overwrite, output underflow and conversion finished. Each flag raises a request only when its own enable bit and the global module enable are both set. The inputs are the queue occupancy counts, access strobes, a conversion-done pulse and a flag write port. The outputs are one CPU interrupt line and two DMA request levels.

The two level-based sources, input-low and output-high, can each be routed to a DMA channel. A routed source drives its DMA request and no longer counts toward the CPU interrupt. When a DMA transfer moves the occupancy to the far side of the programmed trigger count, the block clears the matching flag itself, so the DMA engine is not asked to transfer again. The queues and the conversion datapath are outside this block.

Top module: `fifo_irq_dma_ctrl`

## Requirements
- R1: After reset all five flags, `cpu_irq`, `dma_req_in` and `dma_req_out` are 0.
- R2: The input-low flag (flag bit 0) is set at the clock edge that samples `in_level <= in_trig`.
- R3: The output-high flag (flag bit 1) is set at the clock edge that samples `out_level >= out_trig`.
- R4: The input-low flag is cleared at the clock edge that samples `dma_in_wr` high with `in_level > in_trig`. `in_level` is the count that already includes that write.
- R5: The output-high flag is cleared at the clock edge that samples `dma_out_rd` high with `out_level < out_trig`. `out_level` is the count that already includes that read.
- R6: The overwrite flag (flag bit 2) is set by `out_wr` while `out_level` equals DEPTH. It then stays set until software clears it.
- R7: The underflow flag (flag bit 3) is set by `out_rd` while `out_level` is 0. It then stays set until software clears it.
- R8: A one-cycle `conv_done` pulse sets the conversion-finished flag (flag bit 4).
- R9: A cycle with `flag_wr` high clears every flag whose `flag_wdata` bit is 0 and leaves every flag whose bit is 1 unchanged. If a set condition occurs in the same cycle, the flag ends up set.
- R10: With `mod_en` low, `cpu_irq`, `dma_req_in` and `dma_req_out` are 0 in that same cycle. The flags keep their values.
- R11: `dma_req_in` equals flag0 & `src_en[0]` & `mod_en` & `dma_sel_in`. `dma_req_out` equals flag1 & `src_en[1]` & `mod_en` & `dma_sel_out`. Flags 2 to 4 never produce a DMA request.
- R12: `cpu_irq` is a register loaded each cycle with the OR of (flag & `src_en`) over all sources not routed to DMA. The output is that register gated by the live `mod_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mod_en | input | 1 | Global module enable |
| src_en | input | 5 | Per-source enable, bit order as the flag bits |
| dma_sel_in | input | 1 | Route the input-low source to DMA |
| dma_sel_out | input | 1 | Route the output-high source to DMA |
| in_trig | input | LVL_W | Input trigger count |
| out_trig | input | LVL_W | Output trigger count |
| in_level | input | LVL_W | Input queue occupancy |
| out_level | input | LVL_W | Output queue occupancy |
| dma_in_wr | input | 1 | DMA write into the input queue (level already updated) |
| dma_out_rd | input | 1 | DMA read from the output queue (level already updated) |
| out_wr | input | 1 | Write attempt into the output queue |
| out_rd | input | 1 | Read attempt from the output queue |
| conv_done | input | 1 | Conversion finished pulse |
| flag_wr | input | 1 | Flag write strobe |
| flag_wdata | input | 5 | Flag write data, 0 clears |
| flags | output | 5 | Current flag values |
| cpu_irq | output | 1 | CPU interrupt level |
| dma_req_in | output | 1 | DMA request for the input queue |
| dma_req_out | output | 1 | DMA request for the output queue |

## Verification
The hardest situation to reach is a hardware clear. It needs a DMA strobe to coincide with an occupancy on the far side of the trigger. Meanwhile the routing select, the enables and a software write can each hide or override the outcome. The stimulus therefore draws levels from a narrow band around randomly chosen trigger counts, and it biases the DMA strobes high. That makes threshold crossings with DMA frequent. Directed sequences add a same-cycle set and software clear, and a drop of `mod_en` while requests are pending.

// File: rtl/fifo_irq_pkg.sv
package fifo_irq_pkg;
  localparam int unsigned NSRC    = 5;
  localparam int unsigned SRC_IN  = 0;
  localparam int unsigned SRC_OUT = 1;
  localparam int unsigned SRC_OVW = 2;
  localparam int unsigned SRC_UDF = 3;
  localparam int unsigned SRC_CNV = 4;
  localparam logic [NSRC-1:0] DMA_CAPABLE = 5'b00011;
  typedef logic [NSRC-1:0] src_vec_t;
endpackage

// File: rtl/fifo_irq_events.sv
module fifo_irq_events
  import fifo_irq_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned LVL_W = $clog2(DEPTH + 1)
) (
  input  logic [LVL_W-1:0] in_trig,
  input  logic [LVL_W-1:0] out_trig,
  input  logic [LVL_W-1:0] in_level,
  input  logic [LVL_W-1:0] out_level,
  input  logic             dma_in_wr,
  input  logic             dma_out_rd,
  input  logic             out_wr,
  input  logic             out_rd,
  input  logic             conv_done,
  output src_vec_t         set_ev,
  output src_vec_t         hw_clr
);
  localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(DEPTH);

  logic in_low, out_high;

  always_comb begin
    in_low   = (in_level <= in_trig);
    out_high = (out_level >= out_trig);

    set_ev          = '0;
    set_ev[SRC_IN]  = in_low;
    set_ev[SRC_OUT] = out_high;
    set_ev[SRC_OVW] = out_wr & (out_level == FULL_LVL);
    set_ev[SRC_UDF] = out_rd & (out_level == '0);
    set_ev[SRC_CNV] = conv_done;

    hw_clr          = '0;
    hw_clr[SRC_IN]  = dma_in_wr & ~in_low;
    hw_clr[SRC_OUT] = dma_out_rd & ~out_high;
  end
endmodule

// File: rtl/fifo_irq_flag.sv
module fifo_irq_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  logic flag_d, flag_en;

  always_comb begin
    flag_en = set_i | clr_i;
    flag_d  = set_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag_o <= 1'b0;
    else if (flag_en) flag_o <= flag_d;
  end
endmodule

// File: rtl/fifo_irq_route.sv
module fifo_irq_route
  import fifo_irq_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     mod_en,
  input  src_vec_t src_en,
  input  src_vec_t flag_q,
  input  logic     dma_sel_in,
  input  logic     dma_sel_out,
  output logic     cpu_irq,
  output logic     dma_req_in,
  output logic     dma_req_out
);
  src_vec_t route, armed, to_cpu;
  logic     irq_d, irq_q;

  always_comb begin
    route          = '0;
    route[SRC_IN]  = dma_sel_in;
    route[SRC_OUT] = dma_sel_out;
    route          = route & DMA_CAPABLE;
    armed          = flag_q & src_en;
    to_cpu         = armed & ~route;
    irq_d          = |to_cpu;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end

  always_comb begin
    cpu_irq     = irq_q & mod_en;
    dma_req_in  = armed[SRC_IN]  & route[SRC_IN]  & mod_en;
    dma_req_out = armed[SRC_OUT] & route[SRC_OUT] & mod_en;
  end
endmodule

// File: rtl/fifo_irq_dma_ctrl.sv
module fifo_irq_dma_ctrl
  import fifo_irq_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mod_en,
  input  logic [4:0]       src_en,
  input  logic             dma_sel_in,
  input  logic             dma_sel_out,
  input  logic [LVL_W-1:0] in_trig,
  input  logic [LVL_W-1:0] out_trig,
  input  logic [LVL_W-1:0] in_level,
  input  logic [LVL_W-1:0] out_level,
  input  logic             dma_in_wr,
  input  logic             dma_out_rd,
  input  logic             out_wr,
  input  logic             out_rd,
  input  logic             conv_done,
  input  logic             flag_wr,
  input  logic [4:0]       flag_wdata,
  output logic [4:0]       flags,
  output logic             cpu_irq,
  output logic             dma_req_in,
  output logic             dma_req_out
);
  logic [1:0] rst_sync;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  src_vec_t set_ev, hw_clr, sw_clr, flag_q;

  fifo_irq_events #(.DEPTH(DEPTH)) u_events (
    .in_trig, .out_trig, .in_level, .out_level,
    .dma_in_wr, .dma_out_rd, .out_wr, .out_rd, .conv_done,
    .set_ev, .hw_clr
  );

  always_comb sw_clr = flag_wr ? ~flag_wdata : '0;

  for (genvar i = 0; i < NSRC; i++) begin : g_flag
    fifo_irq_flag u_flag (
      .clk    (clk),
      .rst_n  (rst_int_n),
      .set_i  (set_ev[i]),
      .clr_i  (sw_clr[i] | hw_clr[i]),
      .flag_o (flag_q[i])
    );
  end

  fifo_irq_route u_route (
    .clk, .rst_n(rst_int_n), .mod_en, .src_en, .flag_q,
    .dma_sel_in, .dma_sel_out, .cpu_irq, .dma_req_in, .dma_req_out
  );

  assign flags = flag_q;
endmodule

// File: rtl/fifo_irq_dma_ctrl_chk.sv
module fifo_irq_dma_ctrl_chk #(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned LVL_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             mod_en,
  input logic [4:0]       src_en,
  input logic             dma_sel_in,
  input logic             dma_sel_out,
  input logic [LVL_W-1:0] in_trig,
  input logic [LVL_W-1:0] out_trig,
  input logic [LVL_W-1:0] in_level,
  input logic [LVL_W-1:0] out_level,
  input logic             dma_in_wr,
  input logic             dma_out_rd,
  input logic             out_wr,
  input logic             out_rd,
  input logic             conv_done,
  input logic             flag_wr,
  input logic [4:0]       flag_wdata,
  input logic [4:0]       flags,
  input logic             cpu_irq,
  input logic             dma_req_in,
  input logic             dma_req_out
);
  p_in_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_level <= in_trig) |=> flags[0]);
  p_out_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_level >= out_trig) |=> flags[1]);
  p_in_clr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_in_wr && in_level > in_trig) |=> !flags[0]);
  p_out_clr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_out_rd && out_level < out_trig) |=> !flags[1]);
  p_ovw_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_wr && out_level == LVL_W'(DEPTH)) |=> flags[2]);
  p_udf_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_rd && out_level == '0) |=> flags[3]);
  p_cnv_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    conv_done |=> flags[4]);
  p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (flags[2] && !(flag_wr && !flag_wdata[2])) |=> flags[2]);
  p_mask_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !mod_en |-> (!cpu_irq && !dma_req_in && !dma_req_out));
  p_dma_in_r11: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req_in |-> (flags[0] && src_en[0] && dma_sel_in && mod_en));
  p_dma_out_r11: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req_out |-> (flags[1] && src_en[1] && dma_sel_out && mod_en));
  p_irq_src_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (mod_en && (|(flags[4:2] & src_en[4:2]))) |=> (cpu_irq || !mod_en));
endmodule

bind fifo_irq_dma_ctrl fifo_irq_dma_ctrl_chk #(.DEPTH(DEPTH)) u_chk (
  .clk, .rst_n(rst_int_n), .mod_en, .src_en, .dma_sel_in, .dma_sel_out,
  .in_trig, .out_trig, .in_level, .out_level, .dma_in_wr, .dma_out_rd,
  .out_wr, .out_rd, .conv_done, .flag_wr, .flag_wdata, .flags,
  .cpu_irq, .dma_req_in, .dma_req_out
);

// File: tb/fifo_irq_dma_ctrl_tb_top.sv
module fifo_irq_dma_ctrl_tb_top;
  localparam int unsigned DEPTH = 16;
  localparam int unsigned LVL_W = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mod_en = 1'b0;
  logic [4:0] src_en = '0;
  logic dma_sel_in = 1'b0, dma_sel_out = 1'b0;
  logic [LVL_W-1:0] in_trig = 5'd2, out_trig = 5'd12;
  logic [LVL_W-1:0] in_level = 5'd10, out_level = 5'd3;
  logic dma_in_wr = 0, dma_out_rd = 0, out_wr = 0, out_rd = 0, conv_done = 0;
  logic flag_wr = 0;
  logic [4:0] flag_wdata = '1;
  logic [4:0] flags;
  logic cpu_irq, dma_req_in, dma_req_out;

  int n_chk = 0, n_bad = 0;
  logic [4:0] m_flags = '0;
  logic m_irq = 1'b0;

  always #2 clk = ~clk;

  fifo_irq_dma_ctrl #(.DEPTH(DEPTH)) dut_i (.*);

  function automatic logic [4:0] next_flags(logic [4:0] f);
    logic [4:0] s, c;
    s[0] = in_level <= in_trig;
    s[1] = out_level >= out_trig;
    s[2] = out_wr && out_level == LVL_W'(DEPTH);
    s[3] = out_rd && out_level == '0;
    s[4] = conv_done;
    c = flag_wr ? ~flag_wdata : 5'b0;
    c[0] = c[0] | (dma_in_wr && in_level > in_trig);
    c[1] = c[1] | (dma_out_rd && out_level < out_trig);
    return s | (f & ~c);
  endfunction

  task automatic chk(string tag, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare();
    chk("R2 R4 flag0", flags[0], m_flags[0]);
    chk("R3 R5 flag1", flags[1], m_flags[1]);
    chk("R6 R9 flag2", flags[2], m_flags[2]);
    chk("R7 R9 flag3", flags[3], m_flags[3]);
    chk("R8 R9 flag4", flags[4], m_flags[4]);
    chk("R12 cpu_irq", cpu_irq, m_irq & mod_en);
    chk("R11 dma_req_in", dma_req_in, m_flags[0] & src_en[0] & mod_en & dma_sel_in);
    chk("R11 dma_req_out", dma_req_out, m_flags[1] & src_en[1] & mod_en & dma_sel_out);
  endtask

  task automatic cycle();
    logic [4:0] route;
    route = {3'b0, dma_sel_out, dma_sel_in};
    @(posedge clk);
    #1;
    m_irq   = |(m_flags & src_en & ~route);
    m_flags = next_flags(m_flags);
    compare();
  endtask

  task automatic idle();
    in_level = 5'd10; in_trig = 5'd2; out_level = 5'd3; out_trig = 5'd12;
    dma_in_wr = 0; dma_out_rd = 0; out_wr = 0; out_rd = 0; conv_done = 0;
    flag_wr = 0; flag_wdata = '1;
  endtask

  initial begin
    #400000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    // R1: reset state
    chk("R1 flags", |flags, 1'b0);
    chk("R1 cpu_irq", cpu_irq, 1'b0);
    chk("R1 dma", dma_req_in | dma_req_out, 1'b0);

    // R2 then R4: input low sets, DMA write past trigger clears (routed to DMA)
    mod_en = 1; src_en = 5'b11111; dma_sel_in = 1;
    in_level = 5'd1; cycle();
    chk("R11 dma_req_in raised", dma_req_in, 1'b1);
    in_level = 5'd3; dma_in_wr = 1; cycle();
    chk("R4 hw clear", flags[0], 1'b0);
    idle();
    // R3 then R5 with CPU routing
    out_level = 5'd12; cycle(); cycle();
    chk("R12 irq from flag1", cpu_irq, 1'b1);
    out_level = 5'd11; dma_out_rd = 1; cycle();
    chk("R5 hw clear", flags[1], 1'b0);
    idle();
    // R6, R7 boundaries
    out_level = LVL_W'(DEPTH); out_wr = 1; out_trig = 5'd17; cycle();
    chk("R6 overwrite", flags[2], 1'b1);
    idle(); out_level = 5'd0; out_rd = 1; out_trig = 5'd5; cycle();
    chk("R7 underflow", flags[3], 1'b1);
    idle();
    // R10: mask keeps flags
    mod_en = 0; cycle();
    chk("R10 masked irq", cpu_irq, 1'b0);
    chk("R10 flags kept", flags[2] & flags[3], 1'b1);
    mod_en = 1;
    // R8 + R9: set wins over clear
    conv_done = 1; flag_wr = 1; flag_wdata = 5'b00000; cycle();
    chk("R9 set wins", flags[4], 1'b1);
    chk("R9 cleared others", flags[2] | flags[3], 1'b0);
    idle(); flag_wr = 1; flag_wdata = 5'b01111; cycle();
    chk("R9 write 0 clears", flags[4], 1'b0);
    idle(); cycle();

    // random phase
    for (int n = 0; n < 4000; n++) begin
      mod_en      = ($urandom_range(0, 7) != 0);
      src_en      = 5'($urandom);
      dma_sel_in  = $urandom_range(0, 1) != 0;
      dma_sel_out = $urandom_range(0, 1) != 0;
      if ($urandom_range(0, 15) == 0) begin
        in_trig  = 5'($urandom_range(0, DEPTH));
        out_trig = 5'($urandom_range(0, DEPTH));
      end
      in_level   = 5'($urandom_range(in_trig > 2 ? in_trig - 2 : 0, in_trig + 2 > DEPTH ? DEPTH : in_trig + 2));
      out_level  = 5'($urandom_range(out_trig > 2 ? out_trig - 2 : 0, out_trig + 2 > DEPTH ? DEPTH : out_trig + 2));
      if ($urandom_range(0, 7) == 0) out_level = ($urandom_range(0, 1) != 0) ? LVL_W'(DEPTH) : '0;
      dma_in_wr  = $urandom_range(0, 2) != 0;
      dma_out_rd = $urandom_range(0, 2) != 0;
      out_wr     = $urandom_range(0, 5) == 0;
      out_rd     = $urandom_range(0, 5) == 0;
      conv_done  = $urandom_range(0, 9) == 0;
      flag_wr    = $urandom_range(0, 5) == 0;
      flag_wdata = 5'($urandom);
      cycle();
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule